// File: doc/BRIEF.md
# Per-Port Carrier Integrity Monitor

This block sits beside one port of a 100 Mb/s repeater. It decides whether each receive carrier event is genuine. An event counts as genuine only when its first symbol is a proper start-of-stream delimiter. Any other carrier is treated as false. For a false carrier the monitor asks the repeater core to jam every other port. The jam is a nibble stream that alternates between 0x3 and 0x4. The request lasts until the false carrier ends, or until a timer expires, whichever happens first.

When false carriers arrive one after another without a genuine event in between, the port is cut off (partitioned). Once partitioned, the port's false carriers no longer cause a jam. A single genuine event that completes brings the port back. Each port has its own instance, and an enable input shuts the function off completely.

Top module: `cim_port_monitor`

## Requirements
- R1: An event starts on a rising edge of `carrier`. If `sof_ok` is 1 in that cycle the event is valid and raises no jam. If `sof_ok` is 0 the event is a false carrier.
- R2: For a false carrier on a port that is not partitioned, `jam_req` goes to 1 in the cycle after the rising carrier edge has been sampled.
- R3: While `jam_req` is 1, `jam_nibble` alternates every cycle between 4'h3 and 4'h4, and the first value is 4'h3. While `jam_req` is 0, `jam_nibble` is 4'h0.
- R4: An event ends on the clock edge that samples `carrier` low, or that samples `eoc` high. After an end, `jam_req` is 0 in the next cycle. A carrier that stays high after `eoc` does not start a new event.
- R5: `jam_req` stays at 1 for at most FC_LIMIT cycles (default 450). After the timer expires it stays at 0 for the rest of that event, even if the carrier is still present.
- R6: When PART_THRESH (default 2) false carriers arrive in a row, `partitioned` goes to 1 in the cycle after the start of the last of them. That last false carrier still raises a jam.
- R7: A false carrier that starts while the port is partitioned raises no jam.
- R8: When a valid event ends, the count of consecutive false carriers is cleared. `partitioned` drops to 0 in the next cycle.
- R9: While `enable` is 0, `jam_req` and `partitioned` are 0 in the same cycle and carrier events are ignored. The next clock edge also clears the count of consecutive false carriers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock (25 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns the monitor on |
| carrier | input | 1 | Receive carrier present, one value per symbol |
| sof_ok | input | 1 | First symbol of the carrier is a valid start-of-stream delimiter |
| eoc | input | 1 | Marks the last symbol of the carrier event |
| jam_req | output | 1 | Request to jam all other ports |
| partitioned | output | 1 | Port is isolated |
| jam_nibble | output | 4 | Jam pattern nibble |

## Verification
The assertions assume that `sof_ok` matters only in the cycle in which `carrier` rises. They also assume that `eoc` is never raised in that same cycle. The timer and jam checks assume that an event lasts at least one cycle after its start.

Every directed task keeps to these rules. It raises `carrier` with `sof_ok` already settled and keeps `eoc` low at the rising edge. It holds the carrier for a few cycles, then ends the event either by dropping `carrier` or by a single `eoc` pulse. Between events it leaves `carrier` low for at least one cycle.

// File: rtl/cim_pkg.sv
package cim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_VALID = 2'd1,
      ST_JAM   = 2'd2,
      ST_HOLD  = 2'd3
   } cim_state_e;

   localparam int unsigned NIB_W = 4;
   localparam logic [NIB_W-1:0] JAM_NIB_EVEN = 4'h3;
   localparam logic [NIB_W-1:0] JAM_NIB_ODD  = 4'h4;
   localparam logic [NIB_W-1:0] JAM_NIB_IDLE = 4'h0;
endpackage

// File: rtl/cim_fc_timer.sv
module cim_fc_timer #(
   parameter int unsigned FC_LIMIT = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expire
);
   localparam int unsigned CW = (FC_LIMIT < 2) ? 1 : $clog2(FC_LIMIT);
   localparam logic [CW-1:0] LAST = CW'(FC_LIMIT - 1);

   generate
      if (FC_LIMIT < 2) begin : g_bad_limit
         $error("cim_fc_timer: FC_LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (run && !expire)   cnt <= cnt + CW'(1);
   end

   assign expire = (cnt == LAST);

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R5
endmodule

// File: rtl/cim_part_ctl.sv
module cim_part_ctl #(
   parameter int unsigned PART_THRESH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic false_start,
   input  logic valid_done,
   output logic part
);
   generate
      if (PART_THRESH < 1) begin : g_bad_thresh
         $error("cim_part_ctl: PART_THRESH must be at least 1");
      end

      if (PART_THRESH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n || !enable) part <= 1'b0;
            else if (valid_done)   part <= 1'b0;
            else if (false_start)  part <= 1'b1;
         end
      end else begin : g_count
         localparam int unsigned NW = $clog2(PART_THRESH + 1);
         localparam logic [NW-1:0] THR = NW'(PART_THRESH);
         logic [NW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !enable) begin
               cnt  <= '0;
               part <= 1'b0;
            end else if (valid_done) begin
               cnt  <= '0;
               part <= 1'b0;
            end else if (false_start) begin
               if (cnt < THR)            cnt  <= cnt + NW'(1);
               if (cnt >= THR - NW'(1))  part <= 1'b1;
            end
         end

         AST_COUNT_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> (cnt == '0)); // R9
      end
   endgenerate

   AST_PART_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !part); // R9
   AST_PART_REJOIN: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && valid_done) |=> !part); // R8
endmodule

// File: rtl/cim_jam_gen.sv
module cim_jam_gen
   import cim_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   output logic [NIB_W-1:0] nibble
);
   logic phase;

   always_ff @(posedge clk) begin
      if (!rst_n)       phase <= 1'b0;
      else if (start)   phase <= 1'b0;
      else if (active)  phase <= ~phase;
   end

   always_comb begin
      if (!active)     nibble = JAM_NIB_IDLE;
      else if (phase)  nibble = JAM_NIB_ODD;
      else             nibble = JAM_NIB_EVEN;
   end

   AST_JAM_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> (nibble != $past(nibble))); // R3
endmodule

// File: rtl/cim_port_monitor.sv
module cim_port_monitor
   import cim_pkg::*;
#(
   parameter int unsigned FC_LIMIT    = 450,
   parameter int unsigned PART_THRESH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             carrier,
   input  logic             sof_ok,
   input  logic             eoc,
   output logic             jam_req,
   output logic             partitioned,
   output logic [NIB_W-1:0] jam_nibble
);
   cim_state_e state;
   logic       carrier_q;
   logic       jam_q;
   logic       part;
   logic       expire;
   logic       rise, fin;
   logic       start_valid, start_false, valid_done;

   assign rise        = carrier && !carrier_q;
   assign fin         = !carrier || eoc;
   assign start_valid = enable && (state == ST_IDLE) && rise && sof_ok;
   assign start_false = enable && (state == ST_IDLE) && rise && !sof_ok;
   assign valid_done  = enable && (state == ST_VALID) && fin;

   always_ff @(posedge clk) begin
      if (!rst_n) carrier_q <= 1'b0;
      else        carrier_q <= carrier;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         state <= ST_IDLE;
         jam_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_valid) begin
                  state <= ST_VALID;
               end else if (start_false) begin
                  state <= ST_JAM;
                  jam_q <= !part;
               end
            end
            ST_VALID: begin
               if (fin) state <= ST_IDLE;
            end
            ST_JAM: begin
               if (fin) begin
                  state <= ST_IDLE;
                  jam_q <= 1'b0;
               end else if (expire) begin
                  state <= ST_HOLD;
                  jam_q <= 1'b0;
               end
            end
            ST_HOLD: begin
               if (fin) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   cim_fc_timer #(.FC_LIMIT(FC_LIMIT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_false),
      .run    ((state == ST_JAM) && !fin),
      .expire (expire)
   );

   cim_part_ctl #(.PART_THRESH(PART_THRESH)) u_part (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .false_start (start_false),
      .valid_done  (valid_done),
      .part        (part)
   );

   cim_jam_gen u_jam (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_false),
      .active (jam_req),
      .nibble (jam_nibble)
   );

   assign jam_req     = jam_q && enable;
   assign partitioned = part && enable;

   AST_JAM_ONLY_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_q) |-> ($past(rise) && !$past(sof_ok))); // R2
   AST_JAM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(jam_q) && $past(fin)) |-> !jam_q); // R4
   AST_JAM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (jam_q && expire) |=> !jam_q); // R5
   AST_NO_JAM_PART: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_q) |-> !$past(part)); // R7
endmodule

// File: tb/test_cim_port_monitor.sv
module test_cim_port_monitor;
   localparam time CLK_PERIOD = 40ns;
   localparam int  LIMIT      = 450;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       carrier = 1'b0;
   logic       sof_ok = 1'b0;
   logic       eoc = 1'b0;
   logic       jam_req;
   logic       partitioned;
   logic [3:0] jam_nibble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cim_port_monitor i_cim_port_monitor (
      .clk(clk), .rst_n(rst_n), .enable(enable), .carrier(carrier),
      .sof_ok(sof_ok), .eoc(eoc), .jam_req(jam_req),
      .partitioned(partitioned), .jam_nibble(jam_nibble)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic valid_event();
      carrier = 1'b1; sof_ok = 1'b1; step();
      sof_ok = 1'b0;
      check("R1 valid event no jam", jam_req, 0);
      step();
      carrier = 1'b0; step();
   endtask

   task automatic false_event(input int len);
      carrier = 1'b1; sof_ok = 1'b0;
      for (int i = 0; i < len; i++) step();
      carrier = 1'b0; step();
   endtask

   task automatic t_reset();
      check("R9 reset jam", jam_req, 0);
      check("R9 reset partition", partitioned, 0);
      check("R3 reset nibble", jam_nibble, 0);
   endtask

   task automatic t_false_drop();
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R2 jam after false start", jam_req, 1);
      check("R3 first nibble", jam_nibble, 3);
      step();
      check("R3 second nibble", jam_nibble, 4);
      step();
      check("R3 third nibble", jam_nibble, 3);
      carrier = 1'b0; step();
      check("R4 jam ends on carrier drop", jam_req, 0);
      check("R3 idle nibble", jam_nibble, 0);
      valid_event();
   endtask

   task automatic t_false_eoc();
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R2 jam on false start", jam_req, 1);
      eoc = 1'b1; step();
      eoc = 1'b0;
      check("R4 jam ends on eoc", jam_req, 0);
      step();
      check("R4 held carrier no new event", jam_req, 0);
      carrier = 1'b0; step();
      valid_event();
   endtask

   task automatic t_timeout();
      int cnt = 0;
      carrier = 1'b1; sof_ok = 1'b0;
      for (int i = 0; i < LIMIT + 40; i++) begin
         step();
         if (jam_req) cnt++;
      end
      check("R5 jam length equals timer", cnt, LIMIT);
      check("R5 jam low after timeout", jam_req, 0);
      carrier = 1'b0; step();
      valid_event();
   endtask

   task automatic t_partition();
      false_event(2);
      check("R6 one false no partition", partitioned, 0);
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R6 partition on second false", partitioned, 1);
      check("R6 second false still jams", jam_req, 1);
      carrier = 1'b0; step();
      carrier = 1'b1; step();
      check("R7 partitioned port no jam", jam_req, 0);
      carrier = 1'b0; step();
      carrier = 1'b1; sof_ok = 1'b1; step();
      sof_ok = 1'b0;
      check("R8 partition held during valid", partitioned, 1);
      carrier = 1'b0; step();
      check("R8 partition cleared after valid", partitioned, 0);
   endtask

   task automatic t_counter_clear();
      false_event(2);
      valid_event();
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R8 count cleared by valid", partitioned, 0);
      carrier = 1'b0; step();
      valid_event();
   endtask

   task automatic t_disable();
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R9 jam before disable", jam_req, 1);
      enable = 1'b0; #1;
      check("R9 jam off when disabled", jam_req, 0);
      step();
      carrier = 1'b0; step();
      enable = 1'b1;
      false_event(2);
      check("R9 count cleared by disable", partitioned, 0);
      enable = 1'b0;
      carrier = 1'b1; sof_ok = 1'b0; step();
      check("R9 disabled ignores false", jam_req, 0);
      step();
      carrier = 1'b0; step();
      enable = 1'b1;
      carrier = 1'b1; step();
      check("R9 event ignored while disabled", partitioned, 0);
      carrier = 1'b0; step();
      valid_event();
   endtask

   initial begin
      repeat (4) step();
      rst_n = 1'b1;
      enable = 1'b1;
      step();
      t_reset();
      valid_event();
      t_false_drop();
      t_false_eoc();
      t_timeout();
      t_partition();
      t_counter_clear();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule